// File: doc/BRIEF.md
# Page History Bit Updater

This block keeps the referenced and changed history bits of page translations up to date in hardware. It watches two events. The first is a completed page table walk, which carries the matched entry's current referenced and changed bits, the entry's memory address and the kind of access that started the walk (instruction fetch, load or store). The second is a store that hits in the data TLB, which carries the hit entry's index, its current changed bit and the memory address of its page table entry. When history bits must change, the block issues a write request for the in-memory page table entry. For a store hit it also issues a same-cycle update to the data TLB entry. The entry handed back to the TLB on a walk already carries the updated bits, so those bits never need to be written a second time.

The memory write leaves over a valid/ready handshake and is held until it is accepted. While it is outstanding, the block accepts no new walk or store-hit event. If a walk and a store hit arrive in the same cycle, the walk wins and the store hit must wait.

A small real-mode path is also included. When instruction or data translation is switched off, the physical address equals the effective address. Otherwise the translated address is passed through.

Top module: `pte_hist_updater`

## Requirements
- R1: A walk event with access code 00 (fetch), 01 (load) or 11 (treated as load) whose referenced bit is 0 produces, from the cycle after acceptance, a memory write to the walk's entry address with referenced=1 and changed equal to the walk's changed bit.
- R2: A walk event with access code 10 (store) whose referenced or changed bit is 0 produces, from the cycle after acceptance, a memory write to the walk's entry address with referenced=1 and changed=1.
- R3: An accepted store hit whose changed bit is 0 raises the TLB update strobe in the same cycle with the hit index. From the next cycle, it produces a memory write to the hit's entry address with referenced=1 and changed=1.
- R4: No memory write and no TLB update is produced in three cases: a store hit whose changed bit is already 1, a fetch or load walk whose referenced bit is already 1, or a store walk with both bits already 1.
- R5: While a walk event is presented, the returned bits show referenced=1. The returned changed bit is 1 for a store walk and is the walk's own changed bit otherwise.
- R6: With instruction translation disabled, the instruction physical address equals the instruction effective address; with it enabled, it equals the translated address input.
- R7: With data translation disabled, the data physical address equals the data effective address; with it enabled, it equals the translated address input.
- R8: A pending memory write keeps valid, address and bits unchanged until ready is seen, and while it is pending both event ready outputs are low.
- R9: When a walk event is presented, the store-hit ready output is low in that cycle. When no write is pending, a store hit held across to the next cycle is then accepted.
- R10: A synchronous active-low reset clears any pending memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| walk_valid | input | 1 | Walk completion event present |
| walk_ready | output | 1 | Walk event accepted this cycle |
| walk_kind | input | 2 | Access code: 00 fetch, 01 load, 10 store, 11 load |
| walk_pte_addr | input | AW | Memory address of the matched entry |
| walk_r | input | 1 | Entry's current referenced bit |
| walk_c | input | 1 | Entry's current changed bit |
| walk_ret_r | output | 1 | Referenced bit to load into the TLB |
| walk_ret_c | output | 1 | Changed bit to load into the TLB |
| hit_valid | input | 1 | Data TLB store-hit event present |
| hit_ready | output | 1 | Store-hit event accepted this cycle |
| hit_idx | input | IW | Index of the hit TLB entry |
| hit_c | input | 1 | Hit entry's current changed bit |
| hit_pte_addr | input | AW | Memory address of the hit entry's page table entry |
| tlb_upd_valid | output | 1 | Set changed bit in the TLB entry |
| tlb_upd_idx | output | IW | TLB entry to update |
| mem_wr_valid | output | 1 | Memory write request pending |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | AW | Entry address to write |
| mem_wr_r | output | 1 | New referenced bit |
| mem_wr_c | output | 1 | New changed bit |
| ir_en | input | 1 | Instruction translation enabled |
| i_ea | input | EAW | Instruction effective address |
| i_xpa | input | EAW | Translated instruction address |
| i_pa | output | EAW | Instruction physical address |
| dr_en | input | 1 | Data translation enabled |
| d_ea | input | EAW | Data effective address |
| d_xpa | input | EAW | Translated data address |
| d_pa | output | EAW | Data physical address |

## Verification
The bench targets the asymmetry between walk kinds. A load walk with the referenced bit set and the changed bit clear must stay silent, while a store walk with the same bits must write both. A design that keyed on the wrong bit would either issue spurious writes or miss a changed update. It also drives a walk and a store hit in the same cycle and holds the hit. A design that served both at once, or dropped the hit, would show an early ready or a lost TLB update. Finally, it stalls memory ready for many cycles while throwing new events at the block. A design that let a second request overwrite the pending one would show the write address or bits changing before acceptance.

// File: rtl/pte_hist_updater.sv
module pte_hist_updater #(
  parameter int AW  = 32,
  parameter int IW  = 6,
  parameter int EAW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           walk_valid,
  output logic           walk_ready,
  input  logic [1:0]     walk_kind,
  input  logic [AW-1:0]  walk_pte_addr,
  input  logic           walk_r,
  input  logic           walk_c,
  output logic           walk_ret_r,
  output logic           walk_ret_c,
  input  logic           hit_valid,
  output logic           hit_ready,
  input  logic [IW-1:0]  hit_idx,
  input  logic           hit_c,
  input  logic [AW-1:0]  hit_pte_addr,
  output logic           tlb_upd_valid,
  output logic [IW-1:0]  tlb_upd_idx,
  output logic           mem_wr_valid,
  input  logic           mem_wr_ready,
  output logic [AW-1:0]  mem_wr_addr,
  output logic           mem_wr_r,
  output logic           mem_wr_c,
  input  logic           ir_en,
  input  logic [EAW-1:0] i_ea,
  input  logic [EAW-1:0] i_xpa,
  output logic [EAW-1:0] i_pa,
  input  logic           dr_en,
  input  logic [EAW-1:0] d_ea,
  input  logic [EAW-1:0] d_xpa,
  output logic [EAW-1:0] d_pa
);
  localparam logic [1:0] KIND_STORE = 2'b10;

  logic          pend;
  logic [AW-1:0] pend_addr;
  logic          pend_r, pend_c;

  wire walk_store = (walk_kind == KIND_STORE);
  wire walk_need  = walk_store ? !(walk_r && walk_c) : !walk_r;
  wire walk_take  = walk_valid && walk_ready;
  wire hit_take   = hit_valid && hit_ready;
  wire hit_need   = hit_take && !hit_c;

  assign walk_ready = !pend;
  assign hit_ready  = !pend && !walk_valid;

  assign walk_ret_r = 1'b1;
  assign walk_ret_c = walk_store | walk_c;

  assign tlb_upd_valid = hit_need;
  assign tlb_upd_idx   = hit_idx;

  assign mem_wr_valid = pend;
  assign mem_wr_addr  = pend_addr;
  assign mem_wr_r     = pend_r;
  assign mem_wr_c     = pend_c;

  assign i_pa = ir_en ? i_xpa : i_ea;
  assign d_pa = dr_en ? d_xpa : d_ea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_r    <= 1'b0;
      pend_c    <= 1'b0;
    end else if (pend) begin
      if (mem_wr_ready) pend <= 1'b0;
    end else if (walk_take && walk_need) begin
      pend      <= 1'b1;
      pend_addr <= walk_pte_addr;
      pend_r    <= 1'b1;
      pend_c    <= walk_ret_c;
    end else if (hit_need) begin
      pend      <= 1'b1;
      pend_addr <= hit_pte_addr;
      pend_r    <= 1'b1;
      pend_c    <= 1'b1;
    end
  end
endmodule

// File: rtl/pte_hist_updater_chk.sv
module pte_hist_updater_chk #(
  parameter int AW  = 32,
  parameter int IW  = 6,
  parameter int EAW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           walk_valid,
  input logic           walk_ready,
  input logic [1:0]     walk_kind,
  input logic           walk_r,
  input logic           walk_c,
  input logic           walk_ret_r,
  input logic           walk_ret_c,
  input logic           hit_valid,
  input logic           hit_ready,
  input logic           hit_c,
  input logic           tlb_upd_valid,
  input logic           mem_wr_valid,
  input logic           mem_wr_ready,
  input logic [AW-1:0]  mem_wr_addr,
  input logic           mem_wr_r,
  input logic           mem_wr_c,
  input logic           ir_en,
  input logic [EAW-1:0] i_ea,
  input logic [EAW-1:0] i_pa
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_r) && $stable(mem_wr_c)); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !walk_ready && !hit_ready); // R8
  AST_WALK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid |-> !hit_ready); // R9
  AST_TLB_THEN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_upd_valid |=> mem_wr_valid && mem_wr_r && mem_wr_c); // R3
  AST_TLB_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_upd_valid |-> hit_valid && !hit_c); // R4
  AST_RET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid && walk_kind == 2'b10 |-> walk_ret_r && walk_ret_c); // R5
  AST_STORE_WALK_WR: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid && walk_ready && walk_kind == 2'b10 && !walk_c |=> mem_wr_valid && mem_wr_c); // R2
  AST_REAL_I: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_en |-> i_pa == i_ea); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> !mem_wr_valid); // R10
endmodule

bind pte_hist_updater pte_hist_updater_chk #(.AW(AW), .IW(IW), .EAW(EAW)) u_chk (.*);

// File: tb/pte_hist_updater_tb.sv
module pte_hist_updater_tb;
  localparam int AW = 32, IW = 6, EAW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic walk_valid = 0, walk_r = 0, walk_c = 0;
  logic [1:0] walk_kind = 0;
  logic [AW-1:0] walk_pte_addr = 0, hit_pte_addr = 0;
  logic hit_valid = 0, hit_c = 0, mem_wr_ready = 0, ir_en = 0, dr_en = 0;
  logic [IW-1:0] hit_idx = 0;
  logic [EAW-1:0] i_ea = 0, i_xpa = 0, d_ea = 0, d_xpa = 0;
  logic walk_ready, walk_ret_r, walk_ret_c, hit_ready, tlb_upd_valid;
  logic [IW-1:0] tlb_upd_idx;
  logic mem_wr_valid, mem_wr_r, mem_wr_c;
  logic [AW-1:0] mem_wr_addr;
  logic [EAW-1:0] i_pa, d_pa;

  always #2 clk = ~clk;

  pte_hist_updater #(.AW(AW), .IW(IW), .EAW(EAW)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [AW+1:0] wq[$];
  string tq[$];

  task automatic ck(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // drive at negedge, compare 1 ns later, then advance the model for the coming edge
  task automatic step();
    bit busy, wr, hr, st, need, tl;
    #1;
    busy = wq.size() > 0;
    wr = !busy;
    hr = !busy && !walk_valid;
    st = walk_kind == 2'b10;
    ck("R8 walk_ready", walk_ready, wr);
    ck("R9 hit_ready", hit_ready, hr);
    if (walk_valid) begin
      ck("R5 ret_r", walk_ret_r, 1'b1);
      ck("R5 ret_c", walk_ret_c, st ? 1'b1 : walk_c);
    end
    tl = hit_valid && hr && !hit_c;
    ck(hit_valid && hit_c ? "R4 tlb_upd" : "R3 tlb_upd", tlb_upd_valid, tl);
    if (tl) ck("R3 tlb_idx", tlb_upd_idx, hit_idx);
    ck(busy ? "R8 wr_valid" : "R4 wr_valid", mem_wr_valid, busy);
    if (busy && mem_wr_valid) begin
      ck({tq[0], " wr_addr"}, mem_wr_addr, wq[0][AW+1:2]);
      ck({tq[0], " wr_r"}, mem_wr_r, wq[0][1]);
      ck({tq[0], " wr_c"}, mem_wr_c, wq[0][0]);
    end
    ck("R6 i_pa", i_pa, ir_en ? i_xpa : i_ea);
    ck("R7 d_pa", d_pa, dr_en ? d_xpa : d_ea);
    if (!rst_n) begin
      wq.delete(); tq.delete();
    end else begin
      if (busy && mem_wr_ready) begin
        void'(wq.pop_front()); void'(tq.pop_front());
      end
      need = st ? !(walk_r && walk_c) : !walk_r;
      if (walk_valid && wr && need) begin
        wq.push_back({walk_pte_addr, 1'b1, st ? 1'b1 : walk_c});
        tq.push_back(st ? "R2" : "R1");
      end else if (tl) begin
        wq.push_back({hit_pte_addr, 2'b11});
        tq.push_back("R3");
      end
    end
    @(negedge clk);
  endtask

  task automatic walk(logic [1:0] k, logic r, logic c, logic [AW-1:0] a);
    walk_valid = 1; walk_kind = k; walk_r = r; walk_c = c; walk_pte_addr = a;
    step();
    walk_valid = 0;
  endtask

  task automatic hit(logic c, logic [IW-1:0] ix, logic [AW-1:0] a);
    hit_valid = 1; hit_c = c; hit_idx = ix; hit_pte_addr = a;
    step();
    hit_valid = 0;
  endtask

  task automatic drain(int n);
    mem_wr_ready = 1;
    for (int i = 0; i < n; i++) step();
    mem_wr_ready = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();  // R10 reset state
    rst_n = 1;
    step();
    // R1 fetch and load walks
    walk(2'b00, 0, 0, 32'h1000); step(); drain(1);
    walk(2'b01, 0, 1, 32'h1008); drain(2);
    walk(2'b11, 0, 0, 32'h1010); drain(2);
    // R4 silent cases
    walk(2'b01, 1, 0, 32'h1018); step();
    walk(2'b00, 1, 1, 32'h1020); step();
    walk(2'b10, 1, 1, 32'h1028); step();
    hit(1, 6'd5, 32'h1030); step();
    // R2 store walks
    walk(2'b10, 1, 0, 32'h2000); drain(2);
    walk(2'b10, 0, 1, 32'h2008); drain(2);
    walk(2'b10, 0, 0, 32'h2010); drain(2);
    // R3 store hit, long stall to exercise R8
    hit(0, 6'd9, 32'h3000);
    walk_valid = 1; walk_kind = 2'b10; walk_r = 0; walk_c = 0; walk_pte_addr = 32'h3100;
    hit_valid = 1; hit_c = 0; hit_idx = 6'd3; hit_pte_addr = 32'h3200;
    for (int i = 0; i < 6; i++) step();
    walk_valid = 0; hit_valid = 0;
    drain(3);
    // R9 simultaneous walk (no write) and held hit
    walk_valid = 1; walk_kind = 2'b01; walk_r = 1; walk_c = 1; walk_pte_addr = 32'h4000;
    hit_valid = 1; hit_c = 0; hit_idx = 6'd12; hit_pte_addr = 32'h4100;
    step();
    walk_valid = 0;
    step();
    hit_valid = 0;
    drain(2);
    // R6 R7 translation on/off
    ir_en = 1; dr_en = 0; i_ea = 32'h11; i_xpa = 32'h22; d_ea = 32'h33; d_xpa = 32'h44; step();
    ir_en = 0; dr_en = 1; step();
    // R10 reset with a pending write
    walk(2'b00, 0, 0, 32'h5000);
    rst_n = 0; step(); rst_n = 1; step();
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      walk_valid = $urandom_range(0, 2) == 0;
      walk_kind = 2'($urandom); walk_r = 1'($urandom); walk_c = 1'($urandom);
      walk_pte_addr = $urandom;
      hit_valid = $urandom_range(0, 2) == 0;
      hit_c = 1'($urandom); hit_idx = 6'($urandom); hit_pte_addr = $urandom;
      mem_wr_ready = 1'($urandom);
      ir_en = 1'($urandom); dr_en = 1'($urandom);
      i_ea = $urandom; i_xpa = $urandom; d_ea = $urandom; d_xpa = $urandom;
      rst_n = $urandom_range(0, 199) != 0;
      step();
    end
    finish_run();
  end
endmodule